// File: doc/BRIEF.md
# Triggered One-Pulse PWM Timer

This block is an up-counting timer with a single pulse output whose delay and width are both programmable. One compare value sets the period and returns the counter to zero. A second compare value sets the count at which the output goes high, and a third sets the count at which it goes low. Counting moves forward only on cycles where the count-enable input `tick` is high, so a prescaler outside the block sets the rate.

A run can begin in two ways. Software can pulse a start input. An edge on an external trigger pin can also begin a run, and the edge may be chosen as rising, falling or both. A trigger is honoured only while the output is low, so a pulse that is already in progress cannot be cut short. If the stop option is set, the timer halts after one period, which gives one-shot pulses from each trigger.

The high and low compare values are written through buffers. Their new values reach the live compare logic only at a period boundary, so a pulse is never torn by a mid-period update. Sticky match flags report each compare event.

Top module: `trig_pwm_timer`

## Requirements
- R1: While `running` is 1 and `tick` is 1, `count` rises by one each clock. While `running` is 0 or `tick` is 0, `count` holds its value, apart from loads and trigger clears.
- R2: When `count` equals `cmp_a` on a counting clock, `count` becomes 0 at that edge and the period flag is set.
- R3: `pwm_out` is 0 after reset. A counting clock with `count` equal to the live high value sets it to 1. A counting clock with `count` equal to the live low value clears it to 0. If both match on the same clock, the low value wins.
- R4: `edge_sel` encoding is 00 off, 01 rising, 10 falling and 11 both. `trig_in` passes through two synchroniser flops and one edge-history flop, so an accepted edge sets `running` to 1 and clears `count` at the third clock edge after the pin changes.
- R5: A trigger edge that arrives while `pwm_out` is 1 is ignored. It changes neither `count` nor `running`.
- R6: With `stop_sel` at 1, a period match clears `running`. `count` then holds at 0 until the next start or accepted trigger.
- R7: Writes to the high and low buffers reach the live compare values only at a period match. A buffer write made on the same clock as a period match takes effect at the following match. While `running` is 0, a buffer write also loads the live value directly.
- R8: The `flags` bits are: bit 0 for the period match, bit 1 for the low match and bit 2 for the high match. Each bit is set by its compare event and cleared by a 1 on the matching `flag_clr` bit. If a set and a clear arrive on the same clock, the set wins.
- R9: `start_clr` clears `running` and forces `pwm_out` to 0 while `count` holds. `start_set` sets `running`. `cnt_wr` loads `cnt_wdata` into `count`.
- R10: A trigger accepted on the same clock as a period match takes priority. `count` clears, `running` stays 1 even when `stop_sel` is 1, and no compare event or flag comes from that clock.
- R11: After reset, `count` is 0, `running` is 0, `flags` is 0, and the live high and low values equal their parameter defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable from the prescaler |
| start_set | input | 1 | Software start pulse |
| start_clr | input | 1 | Software stop pulse |
| stop_sel | input | 1 | Halt after one period when 1 |
| edge_sel | input | 2 | Trigger edge choice (00 off, 01 rise, 10 fall, 11 both) |
| trig_in | input | 1 | External trigger pin, asynchronous |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| cmp_a | input | CNT_W | Period compare value |
| bufb_wr | input | 1 | Low-compare buffer write strobe |
| bufb_data | input | CNT_W | Low-compare buffer data |
| bufc_wr | input | 1 | High-compare buffer write strobe |
| bufc_data | input | CNT_W | High-compare buffer data |
| flag_clr | input | 3 | Per-bit flag clear |
| count | output | CNT_W | Counter value |
| running | output | 1 | Counter is running |
| pwm_out | output | 1 | Pulse output |
| flags | output | 3 | Sticky match flags |

## Verification
The first pattern is a free-running software start with a period of 10. It shows where the output rises and falls and where the counter wraps. Buffer writes are made in the middle of a period and again on the boundary clock itself, which separates immediate loading from a transfer one period late. Trigger runs cover the edge choices off, rising and both. They show the three-clock synchroniser latency, the one-shot stop, and an edge that is dropped because it arrives while the output is high. A final trigger timed to land on the period match separates the trigger-wins ordering from a stop on that same clock.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   localparam int NUM_FLAGS = 3;
   localparam int FLAG_A    = 0;
   localparam int FLAG_B    = 1;
   localparam int FLAG_C    = 2;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

endpackage

// File: rtl/ptmr_trig.sv
module ptmr_trig
   import ptmr_pkg::*;
#(
   parameter int SYNC_N = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig_in,
   input  logic [1:0] edge_sel,
   output logic       edge_hit
);

   generate
      if (SYNC_N < 2) begin : g_bad_sync
         $error("ptmr_trig: SYNC_N must be at least 2");
      end
   endgenerate

   logic [SYNC_N-1:0] sync_q;
   logic              prev_q;
   logic              rise;
   logic              fall;
   edge_sel_e         sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_N-2:0], trig_in};
         prev_q <= sync_q[SYNC_N-1];
      end
   end

   assign sel  = edge_sel_e'(edge_sel);
   assign rise = sync_q[SYNC_N-1] & ~prev_q;
   assign fall = ~sync_q[SYNC_N-1] & prev_q;

   always_comb begin
      unique case (sel)
         EDGE_RISE: edge_hit = rise;
         EDGE_FALL: edge_hit = fall;
         EDGE_BOTH: edge_hit = rise | fall;
         default:   edge_hit = 1'b0;
      endcase
   end

   // R4: the selector at 00 blocks every edge
   a_r4_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel == 2'b00) |-> !edge_hit);

endmodule

// File: rtl/ptmr_chan.sv
module ptmr_chan #(
   parameter int CNT_W = 16,
   parameter int INIT  = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buf_wr,
   input  logic [CNT_W-1:0] buf_data,
   input  logic             xfer,
   input  logic             idle,
   input  logic             tick_en,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] act,
   output logic             hit
);

   localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT);

   logic [CNT_W-1:0] buf_q;
   logic [CNT_W-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= INIT_V;
         act_q <= INIT_V;
      end else begin
         if (buf_wr) buf_q <= buf_data;
         if (xfer)
            act_q <= buf_q;
         else if (buf_wr && idle)
            act_q <= buf_data;
      end
   end

   assign act = act_q;
   assign hit = tick_en && (cnt == act_q);

   // R7: the period boundary copies the value held before that edge
   a_r7_xfer_old_buf: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (act_q == $past(buf_q)));

   // R7: a write during a run leaves the live value alone
   a_r7_busy_defers: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_wr && !idle && !xfer) |=> $stable(act_q));

endmodule

// File: rtl/trig_pwm_timer.sv
module trig_pwm_timer
   import ptmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int SYNC_N = 2,
   parameter int B_INIT = 0,
   parameter int C_INIT = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 start_set,
   input  logic                 start_clr,
   input  logic                 stop_sel,
   input  logic [1:0]           edge_sel,
   input  logic                 trig_in,
   input  logic                 cnt_wr,
   input  logic [CNT_W-1:0]     cnt_wdata,
   input  logic [CNT_W-1:0]     cmp_a,
   input  logic                 bufb_wr,
   input  logic [CNT_W-1:0]     bufb_data,
   input  logic                 bufc_wr,
   input  logic [CNT_W-1:0]     bufc_data,
   input  logic [NUM_FLAGS-1:0] flag_clr,
   output logic [CNT_W-1:0]     count,
   output logic                 running,
   output logic                 pwm_out,
   output logic [NUM_FLAGS-1:0] flags
);

   localparam int NUM_CH = 2;
   localparam int CH_B   = 0;
   localparam int CH_C   = 1;

   generate
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
         $error("trig_pwm_timer: CNT_W out of range 2..31");
      end
      if (B_INIT < 0 || B_INIT >= (1 << CNT_W)) begin : g_bad_binit
         $error("trig_pwm_timer: B_INIT does not fit CNT_W");
      end
      if (C_INIT < 0 || C_INIT >= (1 << CNT_W)) begin : g_bad_cinit
         $error("trig_pwm_timer: C_INIT does not fit CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0]              cnt_q;
   logic                          run_q;
   logic                          out_q;
   logic [NUM_FLAGS-1:0]          flag_q;
   logic                          edge_hit;
   logic                          trig_go;
   logic                          tick_en;
   logic                          hit_a;
   logic [NUM_FLAGS-1:0]          hit_v;
   logic [NUM_CH-1:0]             ch_wr;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_data;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_act;
   logic [NUM_CH-1:0]             ch_hit;

   ptmr_trig #(.SYNC_N(SYNC_N)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_in  (trig_in),
      .edge_sel (edge_sel),
      .edge_hit (edge_hit)
   );

   // trigger is honoured only at inactive output; software stop wins
   assign trig_go = edge_hit && !out_q && !start_clr;
   // a trigger, a load or a stop replaces the counting step of this clock
   assign tick_en = run_q && tick && !start_clr && !trig_go && !cnt_wr;
   assign hit_a   = tick_en && (cnt_q == cmp_a);

   assign ch_wr[CH_B]   = bufb_wr;
   assign ch_wr[CH_C]   = bufc_wr;
   assign ch_data[CH_B] = bufb_data;
   assign ch_data[CH_C] = bufc_data;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      ptmr_chan #(
         .CNT_W (CNT_W),
         .INIT  ((ch == CH_B) ? B_INIT : C_INIT)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .buf_wr   (ch_wr[ch]),
         .buf_data (ch_data[ch]),
         .xfer     (hit_a),
         .idle     (!run_q),
         .tick_en  (tick_en),
         .cnt      (cnt_q),
         .act      (ch_act[ch]),
         .hit      (ch_hit[ch])
      );
   end

   assign hit_v[FLAG_A] = hit_a;
   assign hit_v[FLAG_B] = ch_hit[CH_B];
   assign hit_v[FLAG_C] = ch_hit[CH_C];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (trig_go) begin
         cnt_q <= '0;
      end else if (cnt_wr) begin
         cnt_q <= cnt_wdata;
      end else if (tick_en) begin
         cnt_q <= hit_a ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (start_clr) begin
         run_q <= 1'b0;
      end else if (trig_go || start_set) begin
         run_q <= 1'b1;
      end else if (hit_a && stop_sel) begin
         run_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else if (start_clr) begin
         out_q <= 1'b0;
      end else if (ch_hit[CH_B]) begin
         out_q <= 1'b0;
      end else if (ch_hit[CH_C]) begin
         out_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         for (int i = 0; i < NUM_FLAGS; i++) begin
            if (hit_v[i])
               flag_q[i] <= 1'b1;
            else if (flag_clr[i])
               flag_q[i] <= 1'b0;
         end
      end
   end

   assign count   = cnt_q;
   assign running = run_q;
   assign pwm_out = out_q;
   assign flags   = flag_q;

   // R1: a plain counting step adds exactly one
   a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick && !start_clr && !cnt_wr && !trig_go && (count != cmp_a))
      |=> (count == $past(count) + 1'b1));

   // R2: a period match returns the counter to zero
   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      hit_a |=> (count == '0));

   // R3: a lone high match drives the pin high
   a_r3_high_on_c: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hit[CH_C] && !ch_hit[CH_B] && !start_clr) |=> pwm_out);

   // R3: a low match always drives the pin low
   a_r3_low_on_b: assert property (@(posedge clk) disable iff (!rst_n)
      ch_hit[CH_B] |=> !pwm_out);

   // R5: with the pin high and no other cause, the counter cannot move
   a_r5_active_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_out && !start_clr && !cnt_wr && !(running && tick)) |=> $stable(count));

   // R6: one-shot mode halts at the period match
   a_r6_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_a && stop_sel && !start_set) |=> !running);

   // R8: flags stay set until cleared
   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag_chk
      a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[f] && !flag_clr[f]) |=> flags[f]);
   end

   // R9: software stop idles the timer and lowers the pin
   a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_clr |=> (!running && !pwm_out));

   // R10: an accepted trigger keeps the timer running from zero
   a_r10_trig_wins: assert property (@(posedge clk) disable iff (!rst_n)
      trig_go |=> (running && (count == '0)));

endmodule

// File: tb/sim_trig_pwm_timer.sv
`timescale 1ns/1ps
module sim_trig_pwm_timer;

   localparam int W = 16;

   typedef struct {
      string req;
      int    sel;
      int    val;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tick = 1'b1;
   logic         start_set = 1'b0;
   logic         start_clr = 1'b0;
   logic         stop_sel = 1'b0;
   logic [1:0]   edge_sel = 2'b00;
   logic         trig_in = 1'b0;
   logic         cnt_wr = 1'b0;
   logic [W-1:0] cnt_wdata = '0;
   logic [W-1:0] cmp_a = '0;
   logic         bufb_wr = 1'b0;
   logic [W-1:0] bufb_data = '0;
   logic         bufc_wr = 1'b0;
   logic [W-1:0] bufc_data = '0;
   logic [2:0]   flag_clr = '0;
   logic [W-1:0] count;
   logic         running;
   logic         pwm_out;
   logic [2:0]   flags;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   trig_pwm_timer #(.CNT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_set(start_set),
      .start_clr(start_clr), .stop_sel(stop_sel), .edge_sel(edge_sel),
      .trig_in(trig_in), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .cmp_a(cmp_a), .bufb_wr(bufb_wr), .bufb_data(bufb_data),
      .bufc_wr(bufc_wr), .bufc_data(bufc_data), .flag_clr(flag_clr),
      .count(count), .running(running), .pwm_out(pwm_out), .flags(flags)
   );

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push(input string req, input int sel, input int val);
      exp_t e;
      e.req = req; e.sel = sel; e.val = val;
      exp_q.push_back(e);
   endtask

   task automatic expect_state(input string req, input int c, input int r, input int o);
      push(req, 0, c);
      push(req, 1, r);
      push(req, 2, o);
   endtask

   // monitor: compare every queued item away from the active edge
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         exp_t e;
         int   act;
         string nm;
         e = exp_q.pop_front();
         case (e.sel)
            0:       begin act = int'(count);   nm = "count";   end
            1:       begin act = int'(running); nm = "running"; end
            2:       begin act = int'(pwm_out); nm = "pwm_out"; end
            default: begin act = int'(flags);   nm = "flags";   end
         endcase
         n_cmp++;
         if (act != e.val) begin
            n_bad++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", e.req, nm, act, e.val, $time);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      // R11 reset state
      expect_state("R11", 0, 0, 0);
      push("R11", 3, 0);

      cmp_a = 16'd9;
      bufb_data = 16'd6; bufb_wr = 1'b1;
      bufc_data = 16'd2; bufc_wr = 1'b1;
      step(1);
      bufb_wr = 1'b0; bufc_wr = 1'b0;

      // software start, period 10, high at 2, low at 6
      start_set = 1'b1;
      step(1);
      start_set = 1'b0;
      expect_state("R9", 0, 1, 0);
      step(3);
      expect_state("R3", 3, 1, 1);           // R7 idle load took effect
      push("R8", 3, 4);
      step(4);
      expect_state("R3", 7, 1, 0);
      push("R8", 3, 6);
      step(2);
      expect_state("R1", 9, 1, 0);
      step(1);
      expect_state("R2", 0, 1, 0);
      push("R2", 3, 7);

      flag_clr = 3'b111;
      step(1);
      flag_clr = 3'b000;
      push("R8", 3, 0);
      push("R1", 0, 1);

      // mid-period buffer writes must wait for the boundary
      bufb_data = 16'd4; bufb_wr = 1'b1;
      bufc_data = 16'd1; bufc_wr = 1'b1;
      step(1);
      bufb_wr = 1'b0; bufc_wr = 1'b0;
      expect_state("R7", 2, 1, 0);
      step(1);
      expect_state("R7", 3, 1, 1);
      step(8);
      expect_state("R7", 1, 1, 0);
      step(1);
      expect_state("R7", 2, 1, 1);
      step(3);
      expect_state("R7", 5, 1, 0);
      step(4);
      push("R2", 0, 9);

      // buffer write on the boundary clock itself
      bufc_data = 16'd3; bufc_wr = 1'b1;
      step(1);
      bufc_wr = 1'b0;
      push("R2", 0, 0);
      step(2);
      expect_state("R7", 2, 1, 1);
      step(11);
      expect_state("R7", 3, 1, 0);
      step(1);
      expect_state("R7", 4, 1, 1);

      // software stop while the pin is high
      start_clr = 1'b1;
      step(1);
      start_clr = 1'b0;
      expect_state("R9", 4, 0, 0);
      step(2);
      expect_state("R1", 4, 0, 0);

      cnt_wdata = 16'd0; cnt_wr = 1'b1;
      step(1);
      cnt_wr = 1'b0;
      push("R9", 0, 0);
      flag_clr = 3'b111;
      step(1);
      flag_clr = 3'b000;
      push("R8", 3, 0);

      // selector off: the pin is ignored
      trig_in = 1'b1;
      step(4);
      expect_state("R4", 0, 0, 0);
      trig_in = 1'b0;
      step(4);
      expect_state("R4", 0, 0, 0);

      // idle write of low value 8 loads the live value
      bufb_data = 16'd8; bufb_wr = 1'b1;
      step(1);
      bufb_wr = 1'b0;

      // rising edge, one-shot
      edge_sel = 2'b01; stop_sel = 1'b1;
      trig_in = 1'b1;
      step(2);
      expect_state("R4", 0, 0, 0);
      step(1);
      expect_state("R4", 0, 1, 0);
      step(1);
      push("R1", 0, 1);
      tick = 1'b0;
      step(3);
      expect_state("R1", 1, 1, 0);
      tick = 1'b1;
      step(3);
      expect_state("R3", 4, 1, 1);
      step(5);
      expect_state("R3", 9, 1, 0);
      step(1);
      expect_state("R6", 0, 0, 0);
      push("R6", 3, 7);
      step(2);
      expect_state("R6", 0, 0, 0);
      flag_clr = 3'b111;
      step(1);
      flag_clr = 3'b000;

      // both edges, free-running; an edge while high is dropped
      edge_sel = 2'b11; stop_sel = 1'b0;
      trig_in = 1'b0;
      step(3);
      expect_state("R4", 0, 1, 0);
      step(4);
      expect_state("R3", 4, 1, 1);
      trig_in = 1'b1;
      step(3);
      expect_state("R5", 7, 1, 1);
      step(2);
      expect_state("R5", 9, 1, 0);
      trig_in = 1'b0;
      step(3);
      expect_state("R4", 0, 1, 0);
      step(1);
      push("R1", 0, 1);

      // trigger lands on the period match with one-shot set
      stop_sel = 1'b1;
      flag_clr = 3'b111;
      step(1);
      flag_clr = 3'b000;
      step(5);
      push("R10", 0, 7);
      trig_in = 1'b1;
      step(3);
      expect_state("R10", 0, 1, 0);
      push("R10", 3, 6);
      step(1);
      expect_state("R10", 1, 1, 0);

      step(2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule